// File: doc/BRIEF.md
# Scatter-Gather Line DMA Sequencer

The sequencer runs a small program of 32-bit words fetched from host memory. The program describes video scan lines. Each write instruction tells the block to move a number of bytes from an internal FIFO to one host address. A scan line that crosses a chunk border of a scatter list is spread over several write instructions. Start-of-line and end-of-line flags mark the first and last piece. The block presents each piece on a write-request port and leaves the data movement to the logic behind that port.

Besides writes, the program can jump, wait for a given video line to begin (field resync), and issue a masked control-register write. Any executed instruction may pulse one of two interrupt lines and may step or clear a wrap-around completion counter. Software compares that counter against buffer tags using a signed difference. After reset the sequencer starts fetching at the address on `start_addr`. An illegal opcode parks it in a fault state until the next reset.

The control is one state machine with five states:
- FETCH_OP: fetch the opcode word.
- FETCH_ARG: fetch the argument words.
- EXEC: a one-cycle state that fires the outputs.
- SYNC_WAIT: wait for the requested line.
- FAULT: parked after an illegal opcode.

Its transitions are:
- FETCH_OP→FETCH_ARG: the instruction has arguments.
- FETCH_OP→SYNC_WAIT: a resync instruction was fetched.
- FETCH_OP→FAULT: the opcode is illegal.
- FETCH_ARG→EXEC: the last argument word was taken.
- SYNC_WAIT→EXEC: the line matches.
- EXEC→FETCH_OP: always.

Top module: `linedma_seq`

## Requirements
- R1: While `rst` is high (synchronous, active high) `fetch_addr` equals `start_addr`, `done_cnt` is 0, `fault` is 0 and no write or register request is issued. The first word taken after reset is fetched from `start_addr`.
- R2: The opcode is word bits 31:28 and the byte count is bits 11:0. Opcode 0x1 is a write followed by one address word. It produces exactly one `wr_req` cycle. In that cycle `wr_addr` is the address word, `wr_len` is the count, `wr_sol` is bit 27 and `wr_eol` is bit 26. This holds for every piece of a split line.
- R3: Words are fetched at consecutive byte addresses, each 4 above the last. The instruction lengths in words are: write 2, jump 2, writerm (0xB) 3, writecm (0xC) 3, writecr (0xD) 4 and resync (0x8) 1. Writerm and writecm consume their words and issue no write or register request.
- R4: Jump (0x7) takes one target word. The next opcode is fetched from that target with its low two bits cleared.
- R5: Resync (0x8) waits until a cycle with `line_start` high and `line_num` equal to the instruction's low LINE_W bits. A line start for another line is ignored, and so is the matching line number without `line_start`. No fetch happens while waiting.
- R6: Bit 24 of an instruction gives one `irq1` pulse of one cycle when the instruction executes. Bit 25 gives the same for `irq2`.
- R7: Bit 16 adds 1 to `done_cnt` when the instruction executes. Bit 17 clears it instead, and the clear wins when both bits are set. The counter wraps modulo 2^CNT_W.
- R8: Writecr (0xD) produces one `cr_we` cycle. In it `cr_addr` is the first argument, `cr_data` the second and `cr_mask` the third, so that the target updates only the bits set in the mask.
- R9: Any other opcode raises `fault`. From then until reset there are no fetches, writes, register requests or interrupts.
- R10: `fetch_req` stays high with `fetch_addr` stable until `fetch_valid` is seen. A word is taken only in a cycle where both are high, so fetch latency does not change the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_addr | input | AW | Program start byte address loaded at reset |
| fetch_req | output | 1 | Program word request |
| fetch_addr | output | AW | Byte address of the requested word |
| fetch_data | input | 32 | Returned program word |
| fetch_valid | input | 1 | Returned word is valid this cycle |
| line_start | input | 1 | Pulse at the start of a video line |
| line_num | input | LINE_W | Number of the line that is starting |
| wr_req | output | 1 | One-cycle write request |
| wr_addr | output | AW | Host target address of the write |
| wr_len | output | 12 | Bytes to move from the FIFO |
| wr_sol | output | 1 | Piece starts a scan line |
| wr_eol | output | 1 | Piece ends a scan line |
| cr_we | output | 1 | One-cycle masked register write |
| cr_addr | output | 32 | Register address |
| cr_data | output | 32 | Register value |
| cr_mask | output | 32 | Bits of the register to update |
| irq1 | output | 1 | Interrupt pulse, line class |
| irq2 | output | 1 | Interrupt pulse, control class |
| done_cnt | output | CNT_W | Completion counter |
| fault | output | 1 | Illegal opcode seen, sequencer parked |

## Verification
The bench builds the block with AW=16, LINE_W=10 and CNT_W=4. The narrow counter lets the wrap from 15 back to 0 happen after a handful of resync-gated increments instead of 65536. A fetch port that can withhold `fetch_valid` on alternate cycles puts the split-line program under back-pressure. The bench then compares the logged write pieces with those of a run that has no stalls.

// File: rtl/linedma_pkg.sv
package linedma_pkg;

    localparam logic [3:0] OPC_WRITE   = 4'h1;
    localparam logic [3:0] OPC_JUMP    = 4'h7;
    localparam logic [3:0] OPC_SYNC    = 4'h8;
    localparam logic [3:0] OPC_WRITERM = 4'hB;
    localparam logic [3:0] OPC_WRITECM = 4'hC;
    localparam logic [3:0] OPC_WRITECR = 4'hD;

    localparam int BIT_CNT_INC = 16;
    localparam int BIT_CNT_CLR = 17;
    localparam int BIT_IRQ1    = 24;
    localparam int BIT_IRQ2    = 25;
    localparam int BIT_EOL     = 26;
    localparam int BIT_SOL     = 27;

    localparam int MAX_ARGS = 3;
    localparam int ARG_IW   = $clog2(MAX_ARGS + 1);

    typedef struct packed {
        logic sol;
        logic eol;
        logic irq1;
        logic irq2;
        logic cnt_inc;
        logic cnt_clr;
    } flags_t;

    typedef enum logic [2:0] {
        ST_FETCH_OP,
        ST_FETCH_ARG,
        ST_EXEC,
        ST_SYNC_WAIT,
        ST_FAULT
    } seq_state_e;

endpackage

// File: rtl/linedma_decode.sv
module linedma_decode
    import linedma_pkg::*;
(
    input  logic [31:0]       word,
    output logic [3:0]        op,
    output logic              legal,
    output logic [ARG_IW-1:0] nargs,
    output logic [11:0]       count,
    output flags_t            flags
);

    always_comb begin
        op            = word[31:28];
        count         = word[11:0];
        flags.sol     = word[BIT_SOL];
        flags.eol     = word[BIT_EOL];
        flags.irq1    = word[BIT_IRQ1];
        flags.irq2    = word[BIT_IRQ2];
        flags.cnt_inc = word[BIT_CNT_INC];
        flags.cnt_clr = word[BIT_CNT_CLR];
        legal         = 1'b1;
        nargs         = '0;
        case (word[31:28])
            OPC_WRITE, OPC_JUMP:      nargs = ARG_IW'(1);
            OPC_WRITERM, OPC_WRITECM: nargs = ARG_IW'(2);
            OPC_WRITECR:              nargs = ARG_IW'(3);
            OPC_SYNC:                 nargs = '0;
            default:                  legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/linedma_args.sv
module linedma_args #(
    parameter int N  = 3,
    parameter int IW = $clog2(N + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [IW-1:0]       idx,
    input  logic [31:0]         data,
    output logic [N-1:0][31:0]  q
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                q[g] <= '0;
            end else if (load && idx == IW'(g)) begin
                q[g] <= data;
            end
        end
    end

endmodule

// File: rtl/linedma_count.sv
module linedma_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (inc) begin
            q <= q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/linedma_seq.sv
module linedma_seq
    import linedma_pkg::*;
#(
    parameter int AW     = 32,
    parameter int CNT_W  = 16,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     start_addr,
    output logic              fetch_req,
    output logic [AW-1:0]     fetch_addr,
    input  logic [31:0]       fetch_data,
    input  logic              fetch_valid,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    output logic              wr_req,
    output logic [AW-1:0]     wr_addr,
    output logic [11:0]       wr_len,
    output logic              wr_sol,
    output logic              wr_eol,
    output logic              cr_we,
    output logic [31:0]       cr_addr,
    output logic [31:0]       cr_data,
    output logic [31:0]       cr_mask,
    output logic              irq1,
    output logic              irq2,
    output logic [CNT_W-1:0]  done_cnt,
    output logic              fault
);

    localparam logic [AW-1:0] WORD_STEP = AW'(4);

    seq_state_e              state;
    logic [AW-1:0]           pc;
    logic [31:0]             instr;
    logic [ARG_IW-1:0]       arg_idx;
    logic [MAX_ARGS-1:0][31:0] args;
    logic                    take;
    logic                    exec;
    logic                    cnt_inc;
    logic                    cnt_clr;

    logic [3:0]              nd_op;
    logic                    nd_legal;
    logic [ARG_IW-1:0]       nd_nargs;
    logic [11:0]             nd_count;
    flags_t                  nd_flags;

    logic [3:0]              cd_op;
    logic                    cd_legal;
    logic [ARG_IW-1:0]       cd_nargs;
    logic [11:0]             cd_count;
    flags_t                  cd_flags;

    // decoder on the word arriving from the fetch port
    linedma_decode u_dec_new (
        .word  (fetch_data),
        .op    (nd_op),
        .legal (nd_legal),
        .nargs (nd_nargs),
        .count (nd_count),
        .flags (nd_flags)
    );

    // decoder on the latched instruction being executed
    linedma_decode u_dec_cur (
        .word  (instr),
        .op    (cd_op),
        .legal (cd_legal),
        .nargs (cd_nargs),
        .count (cd_count),
        .flags (cd_flags)
    );

    linedma_args #(.N(MAX_ARGS), .IW(ARG_IW)) u_args (
        .clk  (clk),
        .rst  (rst),
        .load (take && state == ST_FETCH_ARG),
        .idx  (arg_idx),
        .data (fetch_data),
        .q    (args)
    );

    linedma_count #(.CNT_W(CNT_W)) u_count (
        .clk (clk),
        .rst (rst),
        .inc (cnt_inc),
        .clr (cnt_clr),
        .q   (done_cnt)
    );

    assign take = fetch_req && fetch_valid;

    // state register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_FETCH_OP;
            pc      <= start_addr;
            instr   <= '0;
            arg_idx <= '0;
        end else begin
            unique case (state)
                ST_FETCH_OP: begin
                    if (take) begin
                        instr   <= fetch_data;
                        pc      <= pc + WORD_STEP;
                        arg_idx <= '0;
                        if (!nd_legal) begin
                            state <= ST_FAULT;
                        end else if (nd_nargs == '0) begin
                            state <= ST_SYNC_WAIT;
                        end else begin
                            state <= ST_FETCH_ARG;
                        end
                    end
                end
                ST_FETCH_ARG: begin
                    if (take) begin
                        pc      <= pc + WORD_STEP;
                        arg_idx <= arg_idx + ARG_IW'(1);
                        if (arg_idx == cd_nargs - ARG_IW'(1)) begin
                            state <= ST_EXEC;
                        end
                    end
                end
                ST_SYNC_WAIT: begin
                    if (line_start && line_num == instr[LINE_W-1:0]) begin
                        state <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    if (cd_op == OPC_JUMP) begin
                        pc <= {args[0][AW-1:2], 2'b00};
                    end
                    state <= ST_FETCH_OP;
                end
                ST_FAULT: begin
                    state <= ST_FAULT;
                end
                default: begin
                    state <= ST_FAULT;
                end
            endcase
        end
    end

    // output process
    always_comb begin
        exec       = (state == ST_EXEC);
        fetch_req  = (state == ST_FETCH_OP) || (state == ST_FETCH_ARG);
        fetch_addr = pc;
        fault      = (state == ST_FAULT);

        wr_req  = exec && (cd_op == OPC_WRITE);
        wr_addr = args[0][AW-1:0];
        wr_len  = cd_count;
        wr_sol  = wr_req && cd_flags.sol;
        wr_eol  = wr_req && cd_flags.eol;

        cr_we   = exec && (cd_op == OPC_WRITECR);
        cr_addr = args[0];
        cr_data = args[1];
        cr_mask = args[2];

        irq1    = exec && cd_flags.irq1;
        irq2    = exec && cd_flags.irq2;
        cnt_inc = exec && cd_flags.cnt_inc;
        cnt_clr = exec && cd_flags.cnt_clr;
    end

endmodule

// File: rtl/linedma_seq_chk.sv
module linedma_seq_chk #(
    parameter int AW    = 32,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             fetch_req,
    input logic             fetch_valid,
    input logic [AW-1:0]    fetch_addr,
    input logic             wr_req,
    input logic             cr_we,
    input logic             irq1,
    input logic             irq2,
    input logic [CNT_W-1:0] done_cnt,
    input logic             fault
);

    // R10
    fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !fetch_valid) |=> (fetch_req && $stable(fetch_addr)));

    // R6
    irq1_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq1 |=> !irq1);

    // R6
    irq2_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq2 |=> !irq2);

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (done_cnt != $past(done_cnt)) |->
        (done_cnt == CNT_W'($past(done_cnt) + 1'b1) || done_cnt == '0));

    // R9
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    // R9
    fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> (!wr_req && !cr_we && !irq1 && !irq2 && $stable(done_cnt)));

endmodule

bind linedma_seq linedma_seq_chk #(.AW(AW), .CNT_W(CNT_W)) u_seq_chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_req   (fetch_req),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .wr_req      (wr_req),
    .cr_we       (cr_we),
    .irq1        (irq1),
    .irq2        (irq2),
    .done_cnt    (done_cnt),
    .fault       (fault)
);

// File: tb/test_linedma_seq.sv
module test_linedma_seq;

    localparam int AW     = 16;
    localparam int CNT_W  = 4;
    localparam int LINE_W = 10;

    localparam logic [31:0] W_WRITE   = 32'h1000_0000;
    localparam logic [31:0] W_JUMP    = 32'h7000_0000;
    localparam logic [31:0] W_SYNC    = 32'h8000_8000;
    localparam logic [31:0] W_WRITERM = 32'hB000_0000;
    localparam logic [31:0] W_WRITECM = 32'hC000_0000;
    localparam logic [31:0] W_WRITECR = 32'hD000_1000;
    localparam logic [31:0] F_SOL  = 32'h0800_0000;
    localparam logic [31:0] F_EOL  = 32'h0400_0000;
    localparam logic [31:0] F_IRQ2 = 32'h0200_0000;
    localparam logic [31:0] F_IRQ1 = 32'h0100_0000;
    localparam logic [31:0] F_CLR  = 32'h0002_0000;
    localparam logic [31:0] F_INC  = 32'h0001_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [AW-1:0]     start_addr = '0;
    logic              fetch_req;
    logic [AW-1:0]     fetch_addr;
    logic [31:0]       fetch_data;
    logic              fetch_valid;
    logic              line_start = 1'b0;
    logic [LINE_W-1:0] line_num = '0;
    logic              wr_req, wr_sol, wr_eol, cr_we, irq1, irq2, fault;
    logic [AW-1:0]     wr_addr;
    logic [11:0]       wr_len;
    logic [31:0]       cr_addr, cr_data, cr_mask;
    logic [CNT_W-1:0]  done_cnt;

    logic [31:0] mem [0:255];
    logic        stall_mode = 1'b0;
    logic        hold = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0] wl_addr [0:63];
    logic [11:0]   wl_len  [0:63];
    logic          wl_sol  [0:63];
    logic          wl_eol  [0:63];
    logic [AW-1:0] fl_addr [0:255];
    int wn, fn, crn, i1n, i2n;
    logic [31:0] c_addr, c_data, c_mask;

    always #5 clk = ~clk;

    assign fetch_valid = fetch_req && !hold;
    assign fetch_data  = mem[fetch_addr[9:2]];

    always @(posedge clk) hold <= stall_mode ? ~hold : 1'b0;

    linedma_seq #(.AW(AW), .CNT_W(CNT_W), .LINE_W(LINE_W)) i_linedma_seq (
        .clk(clk), .rst(rst), .start_addr(start_addr),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_data(fetch_data), .fetch_valid(fetch_valid),
        .line_start(line_start), .line_num(line_num),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_len(wr_len),
        .wr_sol(wr_sol), .wr_eol(wr_eol),
        .cr_we(cr_we), .cr_addr(cr_addr), .cr_data(cr_data), .cr_mask(cr_mask),
        .irq1(irq1), .irq2(irq2), .done_cnt(done_cnt), .fault(fault)
    );

    // event logger, sampled away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            wn = 0; fn = 0; crn = 0; i1n = 0; i2n = 0;
        end else begin
            if (wr_req && wn < 64) begin
                wl_addr[wn] = wr_addr; wl_len[wn] = wr_len;
                wl_sol[wn] = wr_sol; wl_eol[wn] = wr_eol;
                wn++;
            end
            if (fetch_req && fetch_valid && fn < 256) begin
                fl_addr[fn] = fetch_addr;
                fn++;
            end
            if (cr_we) begin
                c_addr = cr_addr; c_data = cr_data; c_mask = cr_mask;
                crn++;
            end
            if (irq1) i1n++;
            if (irq2) i2n++;
        end
    end

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input longint act, input longint exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 32'hF000_0000;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [AW-1:0] sa);
        @(negedge clk);
        rst = 1'b1;
        start_addr = sa;
        cycles(2);
        rst = 1'b0;
    endtask

    task automatic pulse_line(input logic [LINE_W-1:0] ln);
        line_num = ln;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic t_reset();
        clear_mem();
        mem[16] = W_WRITE | F_SOL | F_EOL | 32'd4; mem[17] = 32'h0100;
        mem[18] = W_JUMP; mem[19] = 32'h0048;
        @(negedge clk);
        rst = 1'b1; start_addr = 16'h0040;
        cycles(2);
        chk_eq("R1 fetch_addr in reset", fetch_addr, 16'h0040);
        chk_eq("R1 done_cnt in reset", done_cnt, 0);
        chk_eq("R1 fault in reset", fault, 0);
        chk_eq("R1 no wr_req in reset", wr_req | cr_we, 0);
        rst = 1'b0;
        cycles(10);
        chk_eq("R1 first fetch address", fl_addr[0], 16'h0040);
    endtask

    task automatic load_split();
        clear_mem();
        mem[16] = W_WRITE | F_SOL | 32'd100;         mem[17] = 32'h1000;
        mem[18] = W_WRITE | 32'd200;                 mem[19] = 32'h2000;
        mem[20] = W_WRITE | F_EOL | 32'd50;          mem[21] = 32'h3000;
        mem[22] = W_WRITE | F_SOL | F_EOL | 32'd8;   mem[23] = 32'h4000;
        mem[24] = W_JUMP;                            mem[25] = 32'h0060;
    endtask

    task automatic check_split(input string req);
        chk_eq({req, " write count"}, wn, 4);
        chk_eq({req, " piece0 addr"}, wl_addr[0], 16'h1000);
        chk_eq({req, " piece0 len"}, wl_len[0], 100);
        chk_eq({req, " piece0 sol/eol"}, {wl_sol[0], wl_eol[0]}, 2'b10);
        chk_eq({req, " piece1 len"}, wl_len[1], 200);
        chk_eq({req, " piece1 sol/eol"}, {wl_sol[1], wl_eol[1]}, 2'b00);
        chk_eq({req, " piece2 addr"}, wl_addr[2], 16'h3000);
        chk_eq({req, " piece2 sol/eol"}, {wl_sol[2], wl_eol[2]}, 2'b01);
        chk_eq({req, " whole line len"}, wl_len[3], 8);
        chk_eq({req, " whole line sol/eol"}, {wl_sol[3], wl_eol[3]}, 2'b11);
    endtask

    // R2 split line pieces, R3 consecutive fetch addresses
    task automatic t_split();
        load_split();
        do_reset(16'h0040);
        cycles(40);
        check_split("R2");
        for (int i = 0; i < 10; i++)
            chk_eq("R3 sequential fetch", fl_addr[i], 16'h0040 + 16'(4 * i));
        chk_eq("R4 self jump refetch", fl_addr[10], 16'h0060);
    endtask

    // R10 stalled fetch gives the same result
    task automatic t_stall();
        load_split();
        stall_mode = 1'b1;
        do_reset(16'h0040);
        cycles(80);
        check_split("R10");
        stall_mode = 1'b0;
    endtask

    // R4 jump target with low bits masked
    task automatic t_jump();
        clear_mem();
        mem[0] = W_JUMP; mem[1] = 32'h0083;
        mem[2] = W_WRITE | F_SOL | F_EOL | 32'd7; mem[3] = 32'hBAD0;
        mem[32] = W_WRITE | F_SOL | F_EOL | 32'd5; mem[33] = 32'h0500;
        mem[34] = W_JUMP; mem[35] = 32'h0088;
        do_reset(16'h0000);
        cycles(30);
        chk_eq("R4 fetch after jump", fl_addr[2], 16'h0080);
        chk_eq("R4 skipped write count", wn, 1);
        chk_eq("R4 target write addr", wl_addr[0], 16'h0500);
    endtask

    // R5 resync wait
    task automatic t_sync();
        clear_mem();
        mem[0] = W_SYNC | 32'h200;
        mem[1] = W_WRITE | F_SOL | F_EOL | 32'h20; mem[2] = 32'h0700;
        mem[3] = W_JUMP; mem[4] = 32'h0000;
        do_reset(16'h0000);
        cycles(10);
        chk_eq("R5 no fetch while waiting", fn, 1);
        pulse_line(10'h100);
        cycles(10);
        chk_eq("R5 other line ignored", wn, 0);
        line_num = 10'h200;
        cycles(5);
        chk_eq("R5 line number without start ignored", wn, 0);
        pulse_line(10'h200);
        cycles(10);
        chk_eq("R5 write after matching line", wn, 1);
        chk_eq("R5 write addr", wl_addr[0], 16'h0700);
        chk_eq("R5 back to sync word", fl_addr[5], 16'h0000);
        chk_eq("R5 waiting again", fn, 6);
    endtask

    // R6 irq pulses, R7 increments, R8 writecr
    task automatic t_flags();
        clear_mem();
        mem[0] = W_WRITE | F_SOL | F_EOL | F_IRQ1 | F_INC | 32'd4; mem[1] = 32'h0010;
        mem[2] = W_WRITE | F_SOL | F_EOL | F_INC | 32'd4;          mem[3] = 32'h0020;
        mem[4] = W_WRITECR | F_IRQ2; mem[5] = 32'h0000_0123;
        mem[6] = 32'hAAAA_5555;      mem[7] = 32'h0000_FFFF;
        mem[8] = W_JUMP;             mem[9] = 32'h0020;
        do_reset(16'h0000);
        cycles(40);
        chk_eq("R6 irq1 pulses", i1n, 1);
        chk_eq("R6 irq2 pulses", i2n, 1);
        chk_eq("R7 counter after two increments", done_cnt, 2);
        chk_eq("R8 writecr count", crn, 1);
        chk_eq("R8 cr_addr", c_addr, 32'h0000_0123);
        chk_eq("R8 cr_data", c_data, 32'hAAAA_5555);
        chk_eq("R8 cr_mask", c_mask, 32'h0000_FFFF);
        chk_eq("R8 writecr is no write", wn, 2);
    endtask

    // R3 writerm/writecm lengths and no side effect
    task automatic t_rmcm();
        clear_mem();
        mem[0] = W_WRITERM; mem[1] = 32'h1111; mem[2] = 32'h2222;
        mem[3] = W_WRITECM; mem[4] = 32'h3333; mem[5] = 32'h4444;
        mem[6] = W_WRITE | F_SOL | F_EOL | 32'd9; mem[7] = 32'h0900;
        mem[8] = W_JUMP; mem[9] = 32'h0020;
        do_reset(16'h0000);
        cycles(40);
        for (int i = 0; i < 10; i++)
            chk_eq("R3 fetch over writerm/writecm", fl_addr[i], 16'(4 * i));
        chk_eq("R3 only one write", wn, 1);
        chk_eq("R3 write addr after rm/cm", wl_addr[0], 16'h0900);
        chk_eq("R3 write len after rm/cm", wl_len[0], 9);
        chk_eq("R3 no register write", crn, 0);
    endtask

    // R7 wrap and clear priority
    task automatic t_count();
        clear_mem();
        mem[0] = W_SYNC | 32'd5;
        mem[1] = W_WRITE | F_SOL | F_EOL | F_INC | 32'd1; mem[2] = 32'h0040;
        mem[3] = W_JUMP; mem[4] = 32'h0000;
        do_reset(16'h0000);
        cycles(5);
        for (int i = 0; i < 15; i++) begin
            pulse_line(10'd5);
            cycles(12);
        end
        chk_eq("R7 count before wrap", done_cnt, 15);
        pulse_line(10'd5); cycles(12);
        pulse_line(10'd5); cycles(12);
        chk_eq("R7 count after wrap", done_cnt, 1);

        clear_mem();
        mem[0] = W_WRITE | F_SOL | F_EOL | F_INC | 32'd1;         mem[1] = 32'h0040;
        mem[2] = W_WRITE | F_SOL | F_EOL | F_INC | F_CLR | 32'd1; mem[3] = 32'h0044;
        mem[4] = W_JUMP; mem[5] = 32'h0010;
        do_reset(16'h0000);
        cycles(30);
        chk_eq("R7 clear wins over increment", done_cnt, 0);
    endtask

    // R9 illegal opcode
    task automatic t_fault();
        clear_mem();
        mem[0] = W_WRITE | F_SOL | F_EOL | 32'd3; mem[1] = 32'h0030;
        mem[2] = 32'h3100_0000 | F_IRQ1 | F_INC;
        mem[3] = W_WRITE | F_SOL | F_EOL | 32'd3; mem[4] = 32'h0034;
        do_reset(16'h0000);
        cycles(20);
        chk_eq("R9 fault raised", fault, 1);
        chk_eq("R9 no fetch after fault", fn, 3);
        chk_eq("R9 fetch_req low", fetch_req, 0);
        chk_eq("R9 no write after fault", wn, 1);
        chk_eq("R9 no irq from faulty word", i1n, 0);
        chk_eq("R9 counter untouched", done_cnt, 0);

        clear_mem();
        do_reset(16'h0040);
        cycles(6);
        chk_eq("R9 opcode F faults", fault, 1);
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_mem();
        t_reset();
        t_split();
        t_stall();
        t_jump();
        t_sync();
        t_flags();
        t_rmcm();
        t_count();
        t_fault();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule